// File: doc/BRIEF.md
# FFT Stage Address and Twiddle Sequencer

This block drives the butterfly schedule of an in-place radix-2 FFT over `N_PTS` points, where `N_PTS` is a power of two of at least 4. After a start pulse it steps through all log2(N) stages. In every stage it issues N/2 butterfly beats. Each beat carries the upper operand address, the lower operand address, the twiddle exponent and the zero-based stage index. Beats leave on a valid/ready handshake, so a butterfly datapath and its memory can consume them at their own pace. After the final beat the block raises a one-cycle completion pulse.

Two orderings are supported. In decimation-in-time order, stage 0 uses the closest operand pairs and the twiddles all equal 1. The pair distance and the twiddle resolution both double at each stage. This order expects its input to be loaded in bit-reversed order. In decimation-in-frequency order, the pair distance starts at N/2 and halves at each stage, and the final stage uses twiddle 1 throughout. This order leaves its results in bit-reversed order. The butterfly arithmetic, the sample memory, the twiddle values and any reordering belong to the surrounding datapath.

Top module: `fft_addr_seq`

## Requirements
- R1: After reset, and until a start is accepted, `valid_o` and `done_o` are low.
- R2: An accepted start yields exactly N/2 beats for each stage index 0, 1, …, log2(N)-1, with the stages in ascending order. That is (N/2)·log2(N) beats in total, and `stage_o` always stays within that range.
- R3: Decimation-in-time addressing (`mode_i` = 0). Stage s has N/2^(s+1) groups of 2^s butterflies each. Beat j of the stage belongs to group g = j / 2^s and has in-group position k = j mod 2^s. Its upper address is g·2^(s+1) + k.
- R4: Decimation-in-time twiddle. The exponent of position k in stage s is k·N/2^(s+1). It is 0 throughout stage 0 and runs 0…N/2-1 in order in the last stage.
- R5: Decimation-in-frequency addressing (`mode_i` = 1). Stage s has 2^s groups of N/2^(s+1) butterflies each. Beat j has group g = j / (N/2^(s+1)) and position n = j mod (N/2^(s+1)). Its upper address is g·N/2^s + n.
- R6: Decimation-in-frequency twiddle. The exponent of position n in stage s is n·2^s. It runs 0…N/2-1 in the first stage and is 0 throughout the last stage.
- R7: Every beat has a lower address equal to the upper address plus the stage's pair distance. That distance is 2^s in time order and N/2^(s+1) in frequency order.
- R8: While `valid_o` is high and `ready_i` is low, all output fields hold their values and `valid_o` stays high.
- R9: `done_o` is high for exactly one cycle. That cycle directly follows the clock edge that completes the last handshake, and `valid_o` is low in it.
- R10: While a run is in progress, `start_i` and changes on `mode_i` have no effect. The ordering is the one sampled with the accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a run (accepted only when idle) |
| mode_i | input | 1 | Ordering: 0 time decimation, 1 frequency decimation |
| ready_i | input | 1 | Consumer accepts the current beat |
| valid_o | output | 1 | A beat is offered |
| top_addr_o | output | log2(N) | Upper operand address |
| bot_addr_o | output | log2(N) | Lower operand address |
| twid_o | output | log2(N)-1 | Twiddle exponent |
| stage_o | output | clog2(log2(N)) | Zero-based stage index |
| done_o | output | 1 | One-cycle run completion pulse |

## Verification
The first beat is offered in the cycle after the edge that samples `start_i`. Each later beat appears in the cycle after the edge that completes the previous handshake. The completion pulse appears in the cycle after the final handshake and is gone one cycle later. The bench drives `start_i`, `mode_i` and `ready_i` on falling edges and compares outputs on falling edges. It advances its own beat index only when it has driven ready with valid high, so the beat it checks is always the one the design must be holding at that moment. Every beat of both orderings at N = 16 is compared with values computed from the group/position arithmetic. The runs use continuous ready, two stall patterns, and start/mode disturbances injected mid-run.

// File: rtl/fft_seq_pkg.sv
package fft_seq_pkg;
  typedef enum logic {
    SEQ_DIT = 1'b0,
    SEQ_DIF = 1'b1
  } seq_mode_e;
endpackage

// File: rtl/fft_bfly_cnt.sv
module fft_bfly_cnt
  import fft_seq_pkg::*;
#(
  parameter int LOG2N = 4,
  parameter int HW    = 3,
  parameter int SW    = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  seq_mode_e     mode_i,
  input  logic          ready_i,
  output logic          busy_o,
  output seq_mode_e     mode_o,
  output logic [HW-1:0] idx_o,
  output logic [SW-1:0] stage_o,
  output logic          done_o
);
  localparam logic [SW-1:0] LAST_STG = SW'(LOG2N - 1);

  logic last_idx, last_stg;
  assign last_idx = &idx_o;
  assign last_stg = (stage_o == LAST_STG);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o  <= 1'b0;
      mode_o  <= SEQ_DIT;
      idx_o   <= '0;
      stage_o <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (!busy_o) begin
        if (start_i) begin
          busy_o  <= 1'b1;
          mode_o  <= mode_i;
          idx_o   <= '0;
          stage_o <= '0;
        end
      end else if (ready_i) begin
        if (last_idx) begin
          idx_o <= '0;
          if (last_stg) begin
            busy_o <= 1'b0;
            done_o <= 1'b1;
          end else begin
            stage_o <= stage_o + SW'(1);
          end
        end else begin
          idx_o <= idx_o + HW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/fft_addr_map.sv
module fft_addr_map
  import fft_seq_pkg::*;
#(
  parameter int LOG2N = 4,
  parameter int AW    = 4,
  parameter int HW    = 3,
  parameter int SW    = 2
) (
  input  seq_mode_e     mode_i,
  input  logic [HW-1:0] idx_i,
  input  logic [SW-1:0] stage_i,
  output logic [AW-1:0] top_o,
  output logic [AW-1:0] bot_o,
  output logic [HW-1:0] twid_o
);
  localparam logic [SW-1:0] MAX_SP = SW'(LOG2N - 1);

  // span log2: pair distance exponent; twiddle shift is its complement in both orders
  logic [SW-1:0] span_lg, tw_sh;
  logic [HW-1:0] pos_mask, pos, grp_bits;

  always_comb begin
    span_lg  = (mode_i == SEQ_DIF) ? (MAX_SP - stage_i) : stage_i;
    tw_sh    = MAX_SP - span_lg;
    pos_mask = (HW'(1) << span_lg) - HW'(1); // wraps to all ones at span_lg == HW
    pos      = idx_i & pos_mask;
    grp_bits = idx_i & ~pos_mask;
    top_o    = ({1'b0, grp_bits} << 1) | {1'b0, pos};
    bot_o    = top_o | (AW'(1) << span_lg);
    twid_o   = pos << tw_sh;
  end
endmodule

// File: rtl/fft_addr_seq.sv
module fft_addr_seq
  import fft_seq_pkg::*;
#(
  parameter int N_PTS = 16,
  localparam int AW    = $clog2(N_PTS),
  localparam int HW    = AW - 1,
  localparam int SW    = (AW > 2) ? $clog2(AW) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          mode_i,
  input  logic          ready_i,
  output logic          valid_o,
  output logic [AW-1:0] top_addr_o,
  output logic [AW-1:0] bot_addr_o,
  output logic [HW-1:0] twid_o,
  output logic [SW-1:0] stage_o,
  output logic          done_o
);
  seq_mode_e     run_mode;
  logic [HW-1:0] bfly_idx;
  logic          busy;

  fft_bfly_cnt #(.LOG2N(AW), .HW(HW), .SW(SW)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .mode_i (seq_mode_e'(mode_i)),
    .ready_i(ready_i),
    .busy_o (busy),
    .mode_o (run_mode),
    .idx_o  (bfly_idx),
    .stage_o(stage_o),
    .done_o (done_o)
  );

  fft_addr_map #(.LOG2N(AW), .AW(AW), .HW(HW), .SW(SW)) u_map (
    .mode_i (run_mode),
    .idx_i  (bfly_idx),
    .stage_i(stage_o),
    .top_o  (top_addr_o),
    .bot_o  (bot_addr_o),
    .twid_o (twid_o)
  );

  assign valid_o = busy;
endmodule

// File: rtl/fft_addr_seq_chk.sv
module fft_addr_seq_chk #(
  parameter int AW    = 4,
  parameter int HW    = 3,
  parameter int SW    = 2,
  parameter int LOG2N = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ready_i,
  input logic          valid_o,
  input logic [AW-1:0] top_addr_o,
  input logic [AW-1:0] bot_addr_o,
  input logic [HW-1:0] twid_o,
  input logic [SW-1:0] stage_o,
  input logic          done_o
);
  assert_hold_on_stall_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i |=> valid_o && $stable(top_addr_o) && $stable(bot_addr_o)
      && $stable(twid_o) && $stable(stage_o));

  assert_pair_gap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (top_addr_o < bot_addr_o) && ($countones(top_addr_o ^ bot_addr_o) == 1));

  assert_stage_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (int'(stage_o) <= LOG2N - 1));

  assert_done_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !valid_o);

  assert_done_after_hs_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(valid_o && ready_i));
endmodule

bind fft_addr_seq fft_addr_seq_chk #(.AW(AW), .HW(HW), .SW(SW), .LOG2N(AW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ready_i   (ready_i),
  .valid_o   (valid_o),
  .top_addr_o(top_addr_o),
  .bot_addr_o(bot_addr_o),
  .twid_o    (twid_o),
  .stage_o   (stage_o),
  .done_o    (done_o)
);

// File: tb/tb_fft_addr_seq.sv
`timescale 1ns/1ps
module tb_fft_addr_seq;
  localparam int N     = 16;
  localparam int LOG2N = 4;
  localparam int HALF  = N / 2;
  localparam int TOTAL = HALF * LOG2N;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic       mode_i = 1'b0;
  logic       ready_i = 1'b1;
  logic       valid_o;
  logic [3:0] top_addr_o, bot_addr_o;
  logic [2:0] twid_o;
  logic [1:0] stage_o;
  logic       done_o;

  int n_run = 0;
  int n_fail = 0;

  always #4 clk_i = ~clk_i;

  fft_addr_seq #(.N_PTS(N)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .mode_i(mode_i),
    .ready_i(ready_i), .valid_o(valid_o), .top_addr_o(top_addr_o),
    .bot_addr_o(bot_addr_o), .twid_o(twid_o), .stage_o(stage_o), .done_o(done_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // dif: ordering; pat: ready pattern; inject: disturb start/mode mid-run
  task automatic run_seq(input bit dif, input int pat, input bit inject);
    int e = 0;
    int cyc = 0;
    bit rdy;
    @(negedge clk_i);
    start_i = 1'b1; mode_i = dif;
    @(negedge clk_i);
    start_i = 1'b0; mode_i = ~dif; // R10: mode change after start has no effect
    while (1) begin
      if (e == TOTAL) begin
        check(done_o == 1'b1, "R9 done", int'(done_o), 1);
        check(valid_o == 1'b0, "R9 valid at done", int'(valid_o), 0);
        ready_i = 1'b1;
        @(negedge clk_i);
        check(done_o == 1'b0, "R9 done width", int'(done_o), 0);
        check(valid_o == 1'b0, "R2 no extra beat", int'(valid_o), 0);
        break;
      end
      begin
        int s   = e / HALF;
        int j   = e % HALF;
        int sp  = dif ? (LOG2N - 1 - s) : s;
        int dst = 1 << sp;
        int g   = j / dst;
        int k   = j % dst;
        int et  = g * 2 * dst + k;
        int ew  = dif ? k * (1 << s) : k * (N >> (s + 1));
        check(valid_o == 1'b1, "R2 valid", int'(valid_o), 1);
        check(int'(stage_o) == s, "R2 stage", int'(stage_o), s);
        check(int'(top_addr_o) == et, dif ? "R5 top" : "R3 top", int'(top_addr_o), et);
        check(int'(bot_addr_o) == et + dst, "R7 bot", int'(bot_addr_o), et + dst);
        check(int'(twid_o) == ew, dif ? "R6 twid" : "R4 twid", int'(twid_o), ew);
      end
      case (pat)
        1:       rdy = (cyc % 3) != 2;
        2:       rdy = (cyc % 2) == 0;
        default: rdy = 1'b1;
      endcase
      ready_i = rdy;
      start_i = inject && (e == 5 || e == HALF);
      if (inject) mode_i = cyc[0];
      @(negedge clk_i);
      start_i = 1'b0;
      if (rdy) e++;
      cyc++;
      if (cyc > 5000) begin
        check(1'b0, "watchdog", cyc, 5000);
        break;
      end
    end
    ready_i = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check(valid_o == 1'b0, "R1 valid reset", int'(valid_o), 0);
    check(done_o == 1'b0, "R1 done reset", int'(done_o), 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    check(valid_o == 1'b0, "R1 idle valid", int'(valid_o), 0);
    check(done_o == 1'b0, "R1 idle done", int'(done_o), 0);
    run_seq(1'b0, 0, 1'b0);
    run_seq(1'b1, 0, 1'b0);
    run_seq(1'b0, 1, 1'b1); // R8 stalls, R10 disturbances
    run_seq(1'b1, 2, 1'b1);
    run_seq(1'b1, 1, 1'b0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule